// File: doc/BRIEF.md
# Distinguished-Point Chain Walker

This block drives the precomputation phase of a time-memory-key trade-off. Starting from a start value, it hands the current chain point to an external block-cipher engine as the key. The plaintext is the same for every request. The ciphertext that comes back is scrambled by a fixed wiring permutation, and the result becomes the next point. Intermediate points are never stored. The walker keeps only the start value and the current point of the chain in flight.

A chain ends when a point has a configurable number of leading zero bits. The walker then offers one record (start, end, number of encryptions) on a valid/ready stream and holds it until the table writer takes it. The table is therefore touched only at distinguished points. A chain that runs past a configured length limit is abandoned. It produces a one-cycle discard pulse and no record. Start values come from a counter that is loaded from a seed when the walker leaves idle, and that steps by one per finished chain.

Top module: `dpc_chain_walker`

## Requirements
- R1: Every encryption request carries `cfg_plaintext` as its text, and the first request of a chain carries the chain's start value as its key.
- R2: At most one request is outstanding. `enc_req_valid` and `enc_req_key` stay stable until `enc_req_ready` is sampled high. After a response that does not end the chain, the next request is raised in the following cycle.
- R3: The next point is the response with the bits of each byte reversed: result bit 8*b+i equals response bit 8*b+7-i, for i from 0 to 7.
- R4: A point is distinguished when its `cfg_zero_bits` most significant bits are all zero. A setting of 0 makes every point distinguished. A setting of 128 accepts only the all-zero point.
- R5: At a distinguished point, a record is offered with `rec_start` equal to the chain's start value, `rec_end` equal to the distinguished point, and `rec_len` equal to the number of encryptions in the chain.
- R6: While `rec_valid` is high and `rec_ready` is low, the record fields stay unchanged and `rec_valid` stays high.
- R7: A chain whose `cfg_max_len`-th encryption (a limit of 0 acts as 1) yields a point that is not distinguished is abandoned. `discard` pulses for one cycle and no record is offered. A distinguished point at exactly the limit is still recorded.
- R8: When the walker leaves idle, the first chain starts at `cfg_seed`. Each following chain starts one above the previous one, wrapping modulo 2^128.
- R9: If `cfg_enable` is low when a chain ends, the walker returns to idle and issues no further requests.
- R10: During and right after reset, `enc_req_valid`, `rec_valid` and `discard` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Keep generating chains |
| cfg_plaintext | input | 128 | Fixed text sent with every request |
| cfg_seed | input | 128 | Start value of the first chain |
| cfg_zero_bits | input | 8 | Count of leading zero bits that marks a distinguished point |
| cfg_max_len | input | 16 | Chain length limit in encryptions |
| enc_req_valid | output | 1 | Request to the cipher engine |
| enc_req_ready | input | 1 | Engine accepts the request |
| enc_req_key | output | 128 | Key of the request (current point) |
| enc_req_text | output | 128 | Text of the request |
| enc_rsp_valid | input | 1 | Ciphertext returned |
| enc_rsp_data | input | 128 | Ciphertext |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Record taken |
| rec_start | output | 128 | Chain start value |
| rec_end | output | 128 | Distinguished end point |
| rec_len | output | 16 | Encryptions in the chain |
| discard | output | 1 | One-cycle pulse for an abandoned chain |

## Verification
The bench models the cipher as a 128-bit multiply-add of key and text, and replays every chain on its own to predict each record and discard in order. It uses a short zero prefix with a loose limit, so chains vary in length and end on real distinguished points. A zero-length prefix with a limit of 1 shows that a distinguished point wins at the limit. A full-width prefix with a small limit shows that aborts produce only discards. A seed just below the top of the counter, combined with a slow engine and a stalling record consumer, exercises counter wrap-around and record holding. After each run, the bench checks that the walker stays quiet once enable has dropped.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_EMIT = 2'd3
    } walk_state_e;

endpackage

// File: rtl/dpc_byte_flip.sv
module dpc_byte_flip #(
    parameter int BLK_W = 128
) (
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout
);
    localparam int NBYTES = BLK_W / 8;

    // Pure wiring: bit order reversed inside every byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b+i] = din[8*b+7-i];
        end
    end
endmodule

// File: rtl/dpc_dp_detect.sv
module dpc_dp_detect #(
    parameter int BLK_W = 128,
    parameter int ZB_W  = $clog2(BLK_W + 1)
) (
    input  logic [BLK_W-1:0] point,
    input  logic [ZB_W-1:0]  zero_bits,
    output logic             hit
);
    logic [BLK_W-1:0] mask;

    // Mask covers the zero_bits most significant positions.
    for (genvar g = 0; g < BLK_W; g++) begin : g_mask
        assign mask[BLK_W-1-g] = (g < int'(zero_bits));
    end

    assign hit = ~|(point & mask);

    always_comb begin
        if (hit && (zero_bits != '0)) begin
            p_msb_clear_r4: assert (point[BLK_W-1] == 1'b0)
                else $error("distinguished point with MSB set");
        end
    end
endmodule

// File: rtl/dpc_chain_walker.sv
module dpc_chain_walker
    import dpc_pkg::*;
#(
    parameter int BLK_W = 128,
    parameter int LEN_W = 16,
    parameter int ZB_W  = $clog2(BLK_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [BLK_W-1:0] cfg_plaintext,
    input  logic [BLK_W-1:0] cfg_seed,
    input  logic [ZB_W-1:0]  cfg_zero_bits,
    input  logic [LEN_W-1:0] cfg_max_len,
    output logic             enc_req_valid,
    input  logic             enc_req_ready,
    output logic [BLK_W-1:0] enc_req_key,
    output logic [BLK_W-1:0] enc_req_text,
    input  logic             enc_rsp_valid,
    input  logic [BLK_W-1:0] enc_rsp_data,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [BLK_W-1:0] rec_start,
    output logic [BLK_W-1:0] rec_end,
    output logic [LEN_W-1:0] rec_len,
    output logic             discard
);
    typedef struct packed {
        walk_state_e      state;
        logic [BLK_W-1:0] cnt;   // start value of the chain in flight
        logic [BLK_W-1:0] key;   // current point / end point
        logic [LEN_W-1:0] len;   // encryptions done in this chain
        logic             disc;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [BLK_W-1:0] next_pt;
    logic             is_dp;
    logic [LEN_W-1:0] len_inc;
    logic [LEN_W-1:0] len_lim;
    logic             at_limit;
    logic [BLK_W-1:0] cnt_inc;

    dpc_byte_flip #(.BLK_W(BLK_W)) i_flip (
        .din  (enc_rsp_data),
        .dout (next_pt)
    );

    dpc_dp_detect #(.BLK_W(BLK_W), .ZB_W(ZB_W)) i_detect (
        .point     (next_pt),
        .zero_bits (cfg_zero_bits),
        .hit       (is_dp)
    );

    assign len_inc  = r_q.len + LEN_W'(1);
    assign len_lim  = (cfg_max_len == '0) ? LEN_W'(1) : cfg_max_len;
    assign at_limit = (len_inc >= len_lim);
    assign cnt_inc  = r_q.cnt + BLK_W'(1);

    always_comb begin
        r_d      = r_q;
        r_d.disc = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_enable) begin
                    r_d.cnt   = cfg_seed;
                    r_d.key   = cfg_seed;
                    r_d.len   = '0;
                    r_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (enc_req_ready) begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (enc_rsp_valid) begin
                    r_d.len = len_inc;
                    if (is_dp) begin
                        r_d.key   = next_pt;
                        r_d.state = ST_EMIT;
                    end else if (at_limit) begin
                        r_d.disc  = 1'b1;
                        r_d.cnt   = cnt_inc;
                        r_d.key   = cnt_inc;
                        r_d.len   = '0;
                        r_d.state = cfg_enable ? ST_REQ : ST_IDLE;
                    end else begin
                        r_d.key   = next_pt;
                        r_d.state = ST_REQ;
                    end
                end
            end
            ST_EMIT: begin
                if (rec_ready) begin
                    r_d.cnt   = cnt_inc;
                    r_d.key   = cnt_inc;
                    r_d.len   = '0;
                    r_d.state = cfg_enable ? ST_REQ : ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.key   <= '0;
            r_q.len   <= '0;
            r_q.disc  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign enc_req_valid = (r_q.state == ST_REQ);
    assign enc_req_key   = r_q.key;
    assign enc_req_text  = cfg_plaintext;
    assign rec_valid     = (r_q.state == ST_EMIT);
    assign rec_start     = r_q.cnt;
    assign rec_end       = r_q.key;
    assign rec_len       = r_q.len;
    assign discard       = r_q.disc;

    // R2: request held until taken
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_req_valid && !enc_req_ready |=> enc_req_valid && $stable(enc_req_key));

    // R2: chain continues with a request in the next cycle
    p_reissue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT) && enc_rsp_valid && !is_dp && !at_limit |=> enc_req_valid);

    // R6: record held under backpressure
    p_rec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_start)
                                    && $stable(rec_end) && $stable(rec_len));

    // R7: record length never beyond the limit
    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_len != '0) && (rec_len <= len_lim));

    // R7: discard never coincides with a record
    p_discard_norec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> !rec_valid);

    // R8: next chain starts one above the recorded start
    p_next_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready && cfg_enable
        |=> enc_req_valid && (enc_req_key == $past(rec_start) + BLK_W'(1)));
endmodule

// File: tb/test_dpc_chain_walker.sv
module test_dpc_chain_walker;
    localparam int BLK_W = 128;
    localparam int LEN_W = 16;
    localparam logic [127:0] MUL = 128'h9E3779B97F4A7C15D1B54A32D192ED03;

    typedef struct packed {
        logic         disc;
        logic [127:0] st;
        logic [127:0] en;
        logic [15:0]  len;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0;
    logic [127:0] cfg_plaintext = '0;
    logic [127:0] cfg_seed = '0;
    logic [7:0]   cfg_zero_bits = '0;
    logic [15:0]  cfg_max_len = '0;
    logic         enc_req_valid;
    logic         enc_req_ready = 1'b0;
    logic [127:0] enc_req_key;
    logic [127:0] enc_req_text;
    logic         enc_rsp_valid = 1'b0;
    logic [127:0] enc_rsp_data = '0;
    logic         rec_valid;
    logic         rec_ready = 1'b0;
    logic [127:0] rec_start;
    logic [127:0] rec_end;
    logic [15:0]  rec_len;
    logic         discard;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    int    items_left = 0;
    bit    stall_mode = 1'b0;
    item_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    dpc_chain_walker #(.BLK_W(BLK_W), .LEN_W(LEN_W)) i_dpc_chain_walker (
        .clk, .rst_n, .cfg_enable, .cfg_plaintext, .cfg_seed, .cfg_zero_bits,
        .cfg_max_len, .enc_req_valid, .enc_req_ready, .enc_req_key, .enc_req_text,
        .enc_rsp_valid, .enc_rsp_data, .rec_valid, .rec_ready, .rec_start,
        .rec_end, .rec_len, .discard
    );

    function automatic logic [127:0] enc_model(input logic [127:0] k, input logic [127:0] p);
        return k * MUL + p;
    endfunction

    function automatic logic [127:0] flip_model(input logic [127:0] v);
        logic [127:0] o;
        for (int b = 0; b < 16; b++)
            for (int i = 0; i < 8; i++)
                o[8*b+i] = v[8*b+7-i];
        return o;
    endfunction

    function automatic bit dp_model(input logic [127:0] v, input int l);
        if (l == 0) return 1'b1;
        return (v >> (128 - l)) == 128'd0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Cipher engine model
    bit           pending = 1'b0;
    int           delay   = 0;
    int           nreq    = 0;
    logic [127:0] held_key;
    always @(negedge clk) begin
        if (enc_rsp_valid) begin
            enc_rsp_valid = 1'b0;
        end else if (pending) begin
            if (delay == 0) begin
                enc_rsp_valid = 1'b1;
                enc_rsp_data  = enc_model(held_key, cfg_plaintext);
                pending       = 1'b0;
            end else begin
                delay--;
            end
        end
        enc_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        if (enc_req_valid && enc_req_ready) begin
            // R2: no second request while one is open
            check(!pending && !enc_rsp_valid, "R2", "outstanding", {127'd0, pending}, 128'd0);
            // R1: fixed text on every request
            check(enc_req_text == cfg_plaintext, "R1", "text", enc_req_text, cfg_plaintext);
            pending  = 1'b1;
            held_key = enc_req_key;
            delay    = stall_mode ? (nreq % 4) : 0;
            nreq++;
        end
    end

    // Monitor and scoreboard
    bit           hold_chk = 1'b0;
    logic [127:0] h_st, h_en;
    logic [15:0]  h_len;
    always @(negedge clk) begin
        if (hold_chk) begin
            check(rec_valid && rec_start == h_st && rec_end == h_en && rec_len == h_len,
                  "R6", "held record", rec_end, h_en);
            hold_chk = 1'b0;
        end
        rec_ready = stall_mode ? (cyc % 2 == 0) : 1'b1;
        if (rec_valid || discard) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected output", {127'd0, discard}, 128'd0);
            end else if (discard) begin
                item_t e;
                e = exp_q.pop_front();
                items_left--;
                check(e.disc, "R7", "discard vs record", {127'd0, discard}, {127'd0, e.disc});
            end else if (rec_ready) begin
                item_t e;
                e = exp_q.pop_front();
                items_left--;
                check(!e.disc, "R7", "record where abort expected", 128'd1, 128'd0);
                check(rec_start == e.st, "R8", "start", rec_start, e.st);
                check(rec_end == e.en, "R5", "end point (R3 R4)", rec_end, e.en);
                check(rec_len == e.len, "R5", "length", {112'd0, rec_len}, {112'd0, e.len});
            end else begin
                hold_chk = 1'b1;
                h_st = rec_start; h_en = rec_end; h_len = rec_len;
            end
        end
    end

    task automatic run_pat(input logic [127:0] pt, input logic [127:0] seed,
                           input int l, input int mx, input int n, input bit stall);
        int lim;
        lim = (mx == 0) ? 1 : mx;
        cfg_plaintext = pt;
        cfg_seed      = seed;
        cfg_zero_bits = 8'(l);
        cfg_max_len   = 16'(mx);
        stall_mode    = stall;
        for (int c = 0; c < n; c++) begin
            logic [127:0] s, k, nx;
            item_t it;
            s = seed + 128'(c);
            k = s;
            for (int len = 1; len <= lim; len++) begin
                nx = flip_model(enc_model(k, pt));
                if (dp_model(nx, l)) begin
                    it = '{disc: 1'b0, st: s, en: nx, len: 16'(len)};
                    exp_q.push_back(it);
                    break;
                end
                if (len >= lim) begin
                    it = '{disc: 1'b1, st: s, en: '0, len: '0};
                    exp_q.push_back(it);
                    break;
                end
                k = nx;
            end
        end
        items_left = n;
        @(negedge clk);
        cfg_enable = 1'b1;
        while (items_left > 1) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        cfg_enable = 1'b0;
        while (items_left > 0) @(negedge clk);
        repeat (20) @(negedge clk);
        // R9: idle once enable dropped
        check(!enc_req_valid && !rec_valid && exp_q.size() == 0, "R9", "idle after run",
              {127'd0, enc_req_valid}, 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!enc_req_valid && !rec_valid && !discard, "R10", "reset outputs",
              {125'd0, enc_req_valid, rec_valid, discard}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!enc_req_valid && !rec_valid && !discard, "R10", "after reset",
              {125'd0, enc_req_valid, rec_valid, discard}, 128'd0);
        // R4 R5: short prefix, loose limit, varied chain lengths
        run_pat(128'h0123456789ABCDEF_FEDCBA9876543210, 128'h1000, 3, 60, 8, 1'b0);
        // R7 R4: every point distinguished, limit 1 -> all records of length 1
        run_pat(128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0, 128'h77, 0, 1, 5, 1'b0);
        // R7: full-width prefix, small limit -> aborts only
        run_pat(128'h0, 128'h42, 128, 3, 4, 1'b0);
        // R8 R6 R2: counter wrap, slow engine, stalling consumer
        run_pat(128'h1111_2222_3333_4444_5555_6666_7777_8888,
                128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFD, 4, 30, 6, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule